// File: doc/BRIEF.md
# Interprocessor Interrupt Command Sequencer

This block accepts writes to a 64-bit interrupt command register and turns each accepted command into delivery requests for the processors of an N-way cluster. For fixed and non-maskable commands, the destination field or a shorthand is expanded into a target mask. The mask is then walked one target per cycle, lowest index first. Each step raises a one-hot fixed-interrupt strobe carrying the vector, or a one-hot NMI strobe.

Alongside delivery, the block keeps a three-state startup status for every processor: halted in INIT, waiting for a startup message, or running. INIT and startup commands sent by processor 0 move a target through these states. An accepted startup command emits a start strobe with the target index and a start address. Any command the block cannot complete raises a one-cycle unhandled pulse, so that a slower agent can take it over. The start strobe is the request to add the target to the active set.

Top module: `ipi_cmd_seq`

## Requirements
- R1: After a synchronous reset the block is in this state: no strobes, `busy` low and `ready` high, processor 0 in running, and every other processor in INIT. The status encoding is 2'b00 INIT, 2'b01 waiting for startup, 2'b10 running.
- R2: In legacy mode (`x2_mode` low) a high-word write stores `wr_data[31:0]` and nothing more. A low-word write combines `wr_data[31:0]` with the stored high word into one command, whose destination is bits 63:56.
- R3: In wide mode (`x2_mode` high) a low-word write carries the whole 64-bit command in `wr_data`, with the destination in bits 63:32. High-word writes are ignored, so a later legacy command still uses the old stored high word.
- R4: For fixed mode (bits 10:8 = 000) and NMI mode (bits 10:8 = 100), the shorthand in bits 19:18 picks the targets. The choices are 00 the destination field, 01 self only, 10 all active processors, and 11 all active except self. A destination of N or above yields no target and no unhandled pulse.
- R5: Targets are served one per cycle in ascending index, starting in the cycle after the write is accepted. A fixed command raises `fix_vld` with `fix_vec` equal to bits 7:0, and an NMI command raises `nmi_vld`. Only one target is strobed at a time, and `busy` is high while targets remain.
- R6: `ready` is the inverse of `busy`, and any write presented while `ready` is low is dropped.
- R7: An INIT command (bits 10:8 = 101) with the level bit 14 clear is ignored. It changes no state and raises no unhandled pulse.
- R8: An INIT command with the level bit set, sent from processor 0 to a destination from 1 to N-1, moves a target that is in INIT to waiting. A target in any other state is left as it is.
- R9: A startup command (bits 10:8 = 110) from processor 0 to a destination from 1 to N-1 is accepted only if the target is waiting. When accepted, the target becomes running, and in the next cycle `start_vld` pulses with `start_tgt` set to the destination and `start_addr` set to bits 7:0 shifted left by 12. A target in any other state is not changed and gives no pulse.
- R10: In these cases `unhandled` pulses in the cycle after the write: a delivery mode other than 000, 100, 101 or 110; an INIT with the level bit set, or a startup, that comes from a processor other than 0 or names a destination outside 1 to N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_lo | input | 1 | Low-word write; triggers a command |
| wr_hi | input | 1 | High-word write; stores in legacy mode |
| wr_data | input | 64 | Write data (all 64 bits used by wide-mode low writes) |
| x2_mode | input | 1 | Wide addressing mode |
| self_idx | input | IDXW | Index of the issuing processor |
| act_mask | input | NCPU | Active processor set |
| ready | output | 1 | Command write can be accepted |
| busy | output | 1 | Target mask still being walked |
| fix_vld | output | NCPU | One-hot fixed-interrupt strobe |
| fix_vec | output | 8 | Vector for the fixed strobe |
| nmi_vld | output | NCPU | One-hot NMI strobe |
| start_vld | output | 1 | Processor-start strobe |
| start_tgt | output | IDXW | Processor being started |
| start_addr | output | 20 | Start address |
| unhandled | output | 1 | Command left for another agent |
| boot_st | output | 2*NCPU | Per-processor startup status, 2 bits each |

## Verification
The hardest situation to reach is an accepted startup. It needs a prior INIT with the level bit set, sent from processor 0 to the same target. The stimulus therefore first sends commands that must be rejected: an INIT with the level bit clear, a startup to a target still in INIT, and INIT from processor 1. After those it sends the real INIT and then two startups, of which only the first may pulse. Holding a write off requires a command presented during a multi-target walk, so an all-but-self delivery is followed at once by a second write, and the bench checks that the dropped command leaves no trace.

// File: rtl/ipi_seq_pkg.sv
// Package: shared field positions, delivery-mode codes and startup states
// for the interrupt command sequencer.
package ipi_seq_pkg;
    localparam int VEC_W   = 8;
    localparam int ADDR_W  = VEC_W + 12;
    localparam int DM_LSB  = 8;
    localparam int LVL_BIT = 14;
    localparam int SH_LSB  = 18;

    localparam logic [2:0] DM_FIXED = 3'b000;
    localparam logic [2:0] DM_NMI   = 3'b100;
    localparam logic [2:0] DM_INIT  = 3'b101;
    localparam logic [2:0] DM_START = 3'b110;

    localparam logic [1:0] SH_FIELD = 2'b00;
    localparam logic [1:0] SH_SELF  = 2'b01;
    localparam logic [1:0] SH_ALL   = 2'b10;
    localparam logic [1:0] SH_OTHER = 2'b11;

    typedef enum logic [1:0] {
        BOOT_INIT = 2'b00,
        BOOT_WAIT = 2'b01,
        BOOT_RUN  = 2'b10
    } boot_st_e;
endpackage

// File: rtl/ipi_cmd_decode.sv
// Module: ipi_cmd_decode
// Purely combinational decode of a full 64-bit command. It produces the
// delivery target mask, the startup requests and the unhandled class.
// Assumes: NCPU >= 2, and that self_idx < NCPU.
module ipi_cmd_decode
    import ipi_seq_pkg::*;
#(
    parameter int NCPU = 4,
    localparam int IDXW = $clog2(NCPU)
) (
    input  logic [63:0]      cmd,
    input  logic             x2_mode,
    input  logic [IDXW-1:0]  self_idx,
    input  logic [NCPU-1:0]  act_mask,
    output logic             dlv_en,
    output logic             dlv_nmi,
    output logic [NCPU-1:0]  dlv_mask,
    output logic [VEC_W-1:0] vec,
    output logic [IDXW-1:0]  dest_idx,
    output logic             init_req,
    output logic             sipi_req,
    output logic             unh
);
    logic [31:0]     dest_val;
    logic            dest_in;
    logic            boot_ok;
    logic [NCPU-1:0] dest_oh;
    logic [NCPU-1:0] self_oh;
    logic [2:0]      mode;
    logic [1:0]      sh;

    // Field extraction and destination range checks.
    always_comb begin
        dest_val = x2_mode ? cmd[63:32] : {24'b0, cmd[63:56]};
        dest_in  = dest_val < 32'(NCPU);
        boot_ok  = dest_in && (dest_val != 32'd0) && (self_idx == '0);
        dest_idx = dest_val[IDXW-1:0];
        dest_oh  = dest_in ? (NCPU'(1) << dest_idx) : '0;
        self_oh  = NCPU'(1) << self_idx;
        mode     = cmd[DM_LSB +: 3];
        sh       = cmd[SH_LSB +: 2];
        vec      = cmd[VEC_W-1:0];
    end

    // Classify the delivery mode and build the target set.
    always_comb begin
        dlv_en   = 1'b0;
        dlv_nmi  = 1'b0;
        dlv_mask = '0;
        init_req = 1'b0;
        sipi_req = 1'b0;
        unh      = 1'b0;
        case (mode)
            DM_FIXED, DM_NMI: begin
                dlv_en  = 1'b1;
                dlv_nmi = (mode == DM_NMI);
                case (sh)
                    SH_FIELD: dlv_mask = dest_oh;
                    SH_SELF:  dlv_mask = self_oh;
                    SH_ALL:   dlv_mask = act_mask;
                    SH_OTHER: dlv_mask = act_mask & ~self_oh;
                    default:  dlv_mask = '0;
                endcase
            end
            DM_INIT: begin
                if (cmd[LVL_BIT]) begin
                    if (boot_ok) init_req = 1'b1;
                    else         unh      = 1'b1;
                end
            end
            DM_START: begin
                if (boot_ok) sipi_req = 1'b1;
                else         unh      = 1'b1;
            end
            default: unh = 1'b1;
        endcase
    end
endmodule

// File: rtl/ipi_target_walker.sv
// Module: ipi_target_walker
// Holds a target mask and serves the lowest set bit each cycle, driving a
// one-hot fixed or NMI strobe. Assumes load is only asserted when idle.
module ipi_target_walker
    import ipi_seq_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NCPU-1:0]  load_mask,
    input  logic             load_nmi,
    input  logic [VEC_W-1:0] load_vec,
    output logic [NCPU-1:0]  fix_vld,
    output logic [NCPU-1:0]  nmi_vld,
    output logic [VEC_W-1:0] vec_out,
    output logic             busy
);
    logic [NCPU-1:0]  mask_q;
    logic             nmi_q;
    logic [VEC_W-1:0] vec_q;
    logic [NCPU-1:0]  low_oh;

    // Isolate the lowest pending target.
    always_comb low_oh = mask_q & (~mask_q + NCPU'(1));

    // Load a new mask or retire the target served this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            nmi_q  <= 1'b0;
            vec_q  <= '0;
        end else if (load) begin
            mask_q <= load_mask;
            nmi_q  <= load_nmi;
            vec_q  <= load_vec;
        end else begin
            mask_q <= mask_q & ~low_oh;
        end
    end

    // Route the current target onto the strobe of its kind.
    always_comb begin
        fix_vld = nmi_q ? '0 : low_oh;
        nmi_vld = nmi_q ? low_oh : '0;
        vec_out = vec_q;
        busy    = |mask_q;
    end
endmodule

// File: rtl/ipi_boot_fsm.sv
// Module: ipi_boot_fsm
// One three-state startup tracker per processor. Processor 0 resets to
// running and the rest to INIT. Requests are pre-qualified by the caller.
module ipi_boot_fsm
    import ipi_seq_pkg::*;
#(
    parameter int NCPU = 4,
    localparam int IDXW = $clog2(NCPU)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_req,
    input  logic              sipi_req,
    input  logic [IDXW-1:0]   tgt,
    output logic [2*NCPU-1:0] st_flat,
    output logic              sipi_ok
);
    boot_st_e st_q [NCPU];

    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
        localparam boot_st_e RST_ST = (i == 0) ? BOOT_RUN : BOOT_INIT;
        // Advance this processor's startup state.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[i] <= RST_ST;
            end else if (tgt == IDXW'(i)) begin
                if (init_req && st_q[i] == BOOT_INIT)      st_q[i] <= BOOT_WAIT;
                else if (sipi_req && st_q[i] == BOOT_WAIT) st_q[i] <= BOOT_RUN;
            end
        end
        // Expose the state on the flattened output.
        always_comb st_flat[2*i +: 2] = st_q[i];
    end

    // A startup is accepted only when its target is waiting.
    always_comb sipi_ok = sipi_req && (st_q[tgt] == BOOT_WAIT);
endmodule

// File: rtl/ipi_cmd_seq.sv
// Module: ipi_cmd_seq (top)
// Interrupt command register front end: high-word store, command decode,
// per-target serialised delivery, startup sequencing and unhandled flag.
// Assumes: writes are only taken while ready is high; wr_lo and wr_hi are
// not asserted together.
module ipi_cmd_seq
    import ipi_seq_pkg::*;
#(
    parameter int NCPU = 4,
    localparam int IDXW = $clog2(NCPU)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [63:0]       wr_data,
    input  logic              x2_mode,
    input  logic [IDXW-1:0]   self_idx,
    input  logic [NCPU-1:0]   act_mask,
    output logic              ready,
    output logic              busy,
    output logic [NCPU-1:0]   fix_vld,
    output logic [VEC_W-1:0]  fix_vec,
    output logic [NCPU-1:0]   nmi_vld,
    output logic              start_vld,
    output logic [IDXW-1:0]   start_tgt,
    output logic [ADDR_W-1:0] start_addr,
    output logic              unhandled,
    output logic [2*NCPU-1:0] boot_st
);
    logic [31:0]      hi_q;
    logic [63:0]      cmd;
    logic             acc;
    logic             dlv_en, dlv_nmi, init_req, sipi_req, unh, sipi_ok;
    logic [NCPU-1:0]  dlv_mask;
    logic [VEC_W-1:0] dec_vec;
    logic [IDXW-1:0]  dest_idx;

    // Store the legacy high word when the block can take writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                          hi_q <= '0;
        else if (wr_hi && ready && !x2_mode) hi_q <= wr_data[31:0];
    end

    // Assemble the full command and qualify the trigger.
    always_comb begin
        cmd = x2_mode ? wr_data : {hi_q, wr_data[31:0]};
        acc = wr_lo && ready;
    end

    ipi_cmd_decode #(.NCPU(NCPU)) u_dec (
        .cmd      (cmd),
        .x2_mode  (x2_mode),
        .self_idx (self_idx),
        .act_mask (act_mask),
        .dlv_en   (dlv_en),
        .dlv_nmi  (dlv_nmi),
        .dlv_mask (dlv_mask),
        .vec      (dec_vec),
        .dest_idx (dest_idx),
        .init_req (init_req),
        .sipi_req (sipi_req),
        .unh      (unh)
    );

    ipi_target_walker #(.NCPU(NCPU)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (acc && dlv_en),
        .load_mask (dlv_mask),
        .load_nmi  (dlv_nmi),
        .load_vec  (dec_vec),
        .fix_vld   (fix_vld),
        .nmi_vld   (nmi_vld),
        .vec_out   (fix_vec),
        .busy      (busy)
    );

    ipi_boot_fsm #(.NCPU(NCPU)) u_boot (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_req (acc && init_req),
        .sipi_req (acc && sipi_req),
        .tgt      (dest_idx),
        .st_flat  (boot_st),
        .sipi_ok  (sipi_ok)
    );

    // Register the start and unhandled pulses for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_vld  <= 1'b0;
            start_tgt  <= '0;
            start_addr <= '0;
            unhandled  <= 1'b0;
        end else begin
            start_vld  <= sipi_ok;
            start_tgt  <= dest_idx;
            start_addr <= {dec_vec, 12'h000};
            unhandled  <= acc && unh;
        end
    end

    // Writes are accepted only between walks.
    always_comb ready = !busy;
endmodule

// File: rtl/ipi_cmd_seq_chk.sv
// Module: ipi_cmd_seq_chk
// Temporal checks on the sequencer's ports, bound into every instance.
module ipi_cmd_seq_chk
    import ipi_seq_pkg::*;
#(
    parameter int NCPU = 4,
    localparam int IDXW = $clog2(NCPU)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_lo,
    input logic              ready,
    input logic              busy,
    input logic [NCPU-1:0]   fix_vld,
    input logic [NCPU-1:0]   nmi_vld,
    input logic              start_vld,
    input logic [IDXW-1:0]   start_tgt,
    input logic              unhandled,
    input logic [2*NCPU-1:0] boot_st
);
    logic [NCPU-1:0] dlv;
    always_comb dlv = fix_vld | nmi_vld;

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dlv)); // R5
    AST_FIX_NMI_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !((|fix_vld) && (|nmi_vld))); // R5
    AST_DLV_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (|dlv) |-> busy); // R5
    AST_ORDER_RISING: assert property (@(posedge clk) disable iff (!rst_n)
        (|dlv) |=> (dlv == '0) || (dlv > $past(dlv))); // R5
    AST_BSP_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        boot_st[1:0] == BOOT_RUN); // R1
    AST_START_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        start_vld |-> $past(wr_lo && ready)); // R9
    AST_START_TGT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        start_vld |-> (start_tgt != '0) && (boot_st[2*start_tgt +: 2] == BOOT_RUN)); // R9
    AST_UNH_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        unhandled |-> $past(wr_lo && ready)); // R10
    AST_NO_START_AND_UNH: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_vld && unhandled)); // R10
endmodule

bind ipi_cmd_seq ipi_cmd_seq_chk #(.NCPU(NCPU)) u_chk (.*);

// File: tb/ipi_cmd_seq_bench.sv
// Bench: a behavioural queue-based model is compared with the design on every clock.
module ipi_cmd_seq_bench;
    localparam int NCPU = 4;
    localparam int IDXW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_lo = 1'b0, wr_hi = 1'b0, x2_mode = 1'b0;
    logic [63:0]       wr_data = '0;
    logic [IDXW-1:0]   self_idx = '0;
    logic [NCPU-1:0]   act_mask = 4'b1011;
    logic              ready, busy, start_vld, unhandled;
    logic [NCPU-1:0]   fix_vld, nmi_vld;
    logic [7:0]        fix_vec;
    logic [IDXW-1:0]   start_tgt;
    logic [19:0]       start_addr;
    logic [2*NCPU-1:0] boot_st;

    ipi_cmd_seq #(.NCPU(NCPU)) u_ipi_cmd_seq (.*);

    always #2 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    string phase = "R1";

    // Model state
    int q[$];
    logic [31:0] m_hi;
    int m_bs [NCPU];
    bit e_start, e_unh, m_on;
    int e_tgt, e_addr, e_vec;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s (%s) actual=%0h expected=%0h at %0t", phase, what, act, exp, $time);
        end
    endtask

    task automatic model_cmd();
        logic [63:0] full;
        logic [31:0] dest;
        logic [2:0]  mode;
        logic [1:0]  sh;
        bit ok;
        full = x2_mode ? wr_data : {m_hi, wr_data[31:0]};
        dest = x2_mode ? full[63:32] : {24'b0, full[63:56]};
        mode = full[10:8];
        sh   = full[19:18];
        ok   = (self_idx == 0) && (dest != 0) && (dest < NCPU);
        if (mode == 3'b000 || mode == 3'b100) begin
            e_vec = int'(full[7:0]);
            for (int i = 0; i < NCPU; i++) begin
                bit hit;
                case (sh)
                    2'b00: hit = (dest == i);
                    2'b01: hit = (self_idx == i);
                    2'b10: hit = act_mask[i];
                    default: hit = act_mask[i] && (self_idx != i);
                endcase
                if (hit) q.push_back(i + ((mode == 3'b100) ? 16 : 0));
            end
        end else if (mode == 3'b101) begin
            if (full[14]) begin
                if (ok) begin
                    if (m_bs[dest] == 0) m_bs[dest] = 1;
                end else e_unh = 1;
            end
        end else if (mode == 3'b110) begin
            if (ok) begin
                if (m_bs[dest] == 1) begin
                    m_bs[dest] = 2;
                    e_start = 1;
                    e_tgt = int'(dest);
                    e_addr = int'(full[7:0]) << 12;
                end
            end else e_unh = 1;
        end else e_unh = 1;
    endtask

    // Model update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_hi = '0;
            for (int i = 0; i < NCPU; i++) m_bs[i] = (i == 0) ? 2 : 0;
            e_start = 0; e_unh = 0; m_on = 1;
        end else begin
            bit idle;
            idle = (q.size() == 0);
            if (!idle) void'(q.pop_front());
            e_start = 0; e_unh = 0;
            if (idle && wr_hi && !x2_mode) m_hi = wr_data[31:0];
            if (idle && wr_lo) model_cmd();
        end
    end

    // Compare with the design shortly after each edge.
    always @(posedge clk) begin
        #1;
        if (m_on) begin
            int ef, en;
            logic [2*NCPU-1:0] eb;
            ef = 0; en = 0;
            if (q.size() > 0) begin
                if (q[0] < 16) ef = 1 << q[0];
                else           en = 1 << (q[0] - 16);
            end
            for (int i = 0; i < NCPU; i++) eb[2*i +: 2] = 2'(m_bs[i]);
            chk(fix_vld == ef, "R5 fixed strobe", fix_vld, ef);
            chk(nmi_vld == en, "R5 nmi strobe", nmi_vld, en);
            if (ef != 0) chk(fix_vec == e_vec, "R5 vector", fix_vec, e_vec);
            chk(busy == (q.size() > 0) && ready == !busy, "R6 busy/ready", {busy, ready}, (q.size() > 0) ? 2 : 1);
            chk(start_vld == e_start, "R9 start strobe", start_vld, e_start);
            if (e_start) begin
                chk(start_tgt == e_tgt, "R9 start target", start_tgt, e_tgt);
                chk(start_addr == e_addr, "R9 start address", start_addr, e_addr);
            end
            chk(unhandled == e_unh, "R10 unhandled", unhandled, e_unh);
            chk(boot_st == eb, "R8 startup status", boot_st, eb);
        end
    end

    function automatic logic [31:0] lo(input logic [2:0] mode, input logic [1:0] sh,
                                       input bit lvl, input logic [7:0] v);
        lo = '0;
        lo[7:0] = v; lo[10:8] = mode; lo[14] = lvl; lo[19:18] = sh;
    endfunction

    task automatic put_lo(input logic [63:0] d);
        @(negedge clk); wr_lo = 1'b1; wr_data = d;
        @(negedge clk); wr_lo = 1'b0;
    endtask
    task automatic put_hi(input logic [31:0] d);
        @(negedge clk); wr_hi = 1'b1; wr_data = {32'b0, d};
        @(negedge clk); wr_hi = 1'b0;
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        phase = "R1"; idle(2);
        // R2: stored high word supplies destination 2
        phase = "R2"; put_hi(32'h0200_0000); put_lo({32'b0, lo(3'b000, 2'b00, 0, 8'h45)}); idle(6);
        // R4: self only, self = 1
        phase = "R4"; self_idx = 2'd1; put_lo({32'b0, lo(3'b000, 2'b01, 0, 8'h50)}); idle(6);
        // R4/R5: NMI to all active
        put_lo({32'b0, lo(3'b100, 2'b10, 0, 8'h00)}); idle(6);
        // R6: all but self, then a write during the walk that must be dropped
        phase = "R6"; self_idx = 2'd0;
        put_lo({32'b0, lo(3'b000, 2'b11, 0, 8'h77)});
        put_lo({32'b0, lo(3'b100, 2'b10, 0, 8'h11)}); idle(6);
        // R4: destination out of range, no target, no unhandled
        phase = "R4"; put_hi(32'h0700_0000); put_lo({32'b0, lo(3'b000, 2'b00, 0, 8'h21)}); idle(4);
        put_hi(32'h0300_0000);
        // R3: wide mode, destination in bits 63:32; high write ignored
        phase = "R3"; x2_mode = 1'b1;
        put_lo({32'd3, lo(3'b000, 2'b00, 0, 8'h66)}); idle(4);
        put_hi(32'h0100_0000);
        put_lo({32'd9, lo(3'b000, 2'b00, 0, 8'h67)}); idle(4);
        x2_mode = 1'b0;
        put_lo({32'b0, lo(3'b000, 2'b00, 0, 8'h68)}); idle(4);
        // R7: INIT with level clear is ignored
        phase = "R7"; put_hi(32'h0200_0000);
        put_lo({32'b0, lo(3'b101, 2'b00, 0, 8'h00)}); idle(3);
        // R9: startup while target still in INIT is ignored
        phase = "R9"; put_lo({32'b0, lo(3'b110, 2'b00, 0, 8'h9A)}); idle(3);
        // R10: INIT from processor 1, and INIT to destination 0
        phase = "R10"; self_idx = 2'd1; put_lo({32'b0, lo(3'b101, 2'b00, 1, 8'h00)}); idle(3);
        self_idx = 2'd0; put_hi(32'h0000_0000); put_lo({32'b0, lo(3'b101, 2'b00, 1, 8'h00)}); idle(3);
        // R8: INIT moves processor 2 to waiting
        phase = "R8"; put_hi(32'h0200_0000); put_lo({32'b0, lo(3'b101, 2'b00, 1, 8'h00)}); idle(3);
        put_lo({32'b0, lo(3'b101, 2'b00, 1, 8'h00)}); idle(3);
        // R9: accepted startup, then a repeat that must not pulse
        phase = "R9"; put_lo({32'b0, lo(3'b110, 2'b00, 0, 8'h9A)}); idle(3);
        put_lo({32'b0, lo(3'b110, 2'b00, 0, 8'h9B)}); idle(3);
        put_hi(32'h0300_0000); put_lo({32'b0, lo(3'b110, 2'b00, 0, 8'h10)}); idle(3);
        // R10: reserved modes and a startup from processor 1
        phase = "R10"; put_lo({32'b0, lo(3'b010, 2'b00, 0, 8'h01)}); idle(2);
        put_lo({32'b0, lo(3'b111, 2'b00, 0, 8'h02)}); idle(2);
        self_idx = 2'd1; put_lo({32'b0, lo(3'b110, 2'b00, 0, 8'h03)}); idle(3);
        self_idx = 2'd0;
        // R1: reset again returns every processor to its initial state
        phase = "R1"; @(negedge clk); rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(3);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule